// File: doc/BRIEF.md
# Twelve-Bit Converter to Eight-Bit Host Bridge

This block connects an 8-bit host bus to a 12-bit parallel-output converter. The converter has a start strobe, a chip select, a read strobe and a busy flag. A host write to the bridge starts a conversion, and the value written is ignored. The host then reads the 12-bit result as two bytes in a fixed order.

The first read takes the upper eight result bits straight from the converter. When that read ends, the four low bits are stored in a holding register inside the bridge. The second read returns those stored bits and does not touch the converter. If the host reads before the conversion has finished, the bridge drives its ready output low until the result is available.

All host strobes are sampled on the bridge clock. The busy flag from the converter passes through a two-flop synchronizer before it is used.

Top module: `adc_byte_bridge`

## Requirements
- R1: A host write (host_cs_n and host_wr_n both low) while no conversion is running produces exactly one clock of cnv_start_n low. The low cycle follows the first clock edge that sees the write, and cnv_cs_n is low during that same cycle.
- R2: A host write made while a conversion is pending or running produces no low level on cnv_start_n and starts no new conversion.
- R3: A host read made while a conversion is pending or running holds host_ready low until the conversion has finished. The read then completes with the new result.
- R4: The first completed read after a conversion start returns result bits 11 to 4 on host_dout[7:0], read from the converter with cnv_cs_n and cnv_rd_n low.
- R5: The second read returns result bits 3 to 0 on host_dout[3:0], with host_dout[7:4] equal to zero. These bits come from the holding register captured when the first read ended, and cnv_rd_n stays high during this read.
- R6: The byte order starts at the upper byte after reset and after every conversion start. After that it alternates upper, lower, upper on each completed read.
- R7: host_dout is zero whenever host_cs_n or host_rd_n is high, and while host_ready is low.
- R8: After reset, cnv_start_n, cnv_cs_n and cnv_rd_n are high, host_ready is high and host_dout is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_cs_n | input | 1 | Host chip select for the bridge, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_dout | output | 8 | Read data to the host |
| host_ready | output | 1 | Low stalls the current host read |
| cnv_start_n | output | 1 | Conversion start pulse to the converter, active low |
| cnv_cs_n | output | 1 | Converter chip select, active low |
| cnv_rd_n | output | 1 | Converter read strobe, active low |
| cnv_busy | input | 1 | Converter busy flag, asynchronous |
| cnv_data | input | 12 | Converter result bus |

## Verification
A wrong byte-order toggle shows at the ports on the very next read: the nibble appears where the upper byte was expected, or a fresh converter read happens when the stored bits were due. A stale or mistimed holding register shows up as a lower byte that belongs to an earlier result. A busy tracker that clears too early lets a read finish with old data one conversion back, and one that never clears leaves host_ready low past the watchdog. The sweep varies both result halves independently, so any corrupted bit shows up within one conversion.

// File: rtl/adc_bridge_pkg.sv
package adc_bridge_pkg;

    // Start and conversion tracking state
    typedef struct packed {
        logic wr_seen;    // write strobe level from the previous cycle
        logic start;      // start pulse register
        logic active;     // conversion pending or running
        logic busy_prev;  // synchronized busy from the previous cycle
    } ctrl_state_t;

endpackage

// File: rtl/adc_bridge_sync.sv
module adc_bridge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/adc_bridge_ctrl.sv
module adc_bridge_ctrl
    import adc_bridge_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_act,
    input  logic busy_s,
    output logic start,
    output logic pending
);
    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.wr_seen   = wr_act;
        st_d.busy_prev = busy_s;
        st_d.start     = wr_act && !st_q.wr_seen && !st_q.active && !busy_s;
        if (st_d.start)
            st_d.active = 1'b1;
        else if (st_q.active && st_q.busy_prev && !busy_s)
            st_d.active = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign start   = st_q.start;
    assign pending = st_q.active || busy_s;

    // R1: the start pulse lasts one clock
    a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.start |=> !st_q.start);
    // R2: a start is only issued when no conversion was being tracked
    a_r2_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.start |-> !$past(st_q.active));
endmodule

// File: rtl/adc_bridge_rdpath.sv
module adc_bridge_rdpath #(
    parameter int RES_W = 12,
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_act,
    input  logic             ready,
    input  logic             start,
    input  logic [RES_W-1:0] cnv_data,
    output logic [BUS_W-1:0] dout,
    output logic             hi_read
);
    localparam int LO_W  = RES_W - BUS_W;
    localparam int PAD_W = BUS_W - LO_W;

    typedef struct packed {
        logic            hi_next;
        logic            rd_seen;
        logic            done;
        logic [LO_W-1:0] snap;
        logic [LO_W-1:0] lo;
    } rd_state_t;

    rd_state_t st_d, st_q;
    logic      read_ok;
    logic      read_end;

    always_comb begin
        read_ok  = rd_act && ready;
        read_end = st_q.rd_seen && !rd_act && st_q.done;

        st_d         = st_q;
        st_d.rd_seen = rd_act;
        if (read_ok) begin
            st_d.done = 1'b1;
            if (st_q.hi_next) st_d.snap = cnv_data[LO_W-1:0];
        end
        if (!rd_act) st_d.done = 1'b0;
        if (read_end) begin
            st_d.hi_next = !st_q.hi_next;
            if (st_q.hi_next) st_d.lo = st_q.snap;
        end
        if (start) st_d.hi_next = 1'b1;

        dout = '0;
        if (read_ok) begin
            if (st_q.hi_next) dout = cnv_data[RES_W-1 -: BUS_W];
            else              dout = {{PAD_W{1'b0}}, st_q.lo};
        end
        hi_read = read_ok && st_q.hi_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.hi_next <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // R6: every conversion start leaves the upper byte next
    a_r6_order_reset: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> st_q.hi_next);
    // R5: the holding register changes only at the end of an upper-byte read
    a_r5_lo_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.rd_seen && !rd_act && st_q.done && st_q.hi_next) |=> $stable(st_q.lo));
endmodule

// File: rtl/adc_byte_bridge.sv
module adc_byte_bridge #(
    parameter int RES_W       = 12,
    parameter int BUS_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_cs_n,
    input  logic             host_rd_n,
    input  logic             host_wr_n,
    output logic [BUS_W-1:0] host_dout,
    output logic             host_ready,
    output logic             cnv_start_n,
    output logic             cnv_cs_n,
    output logic             cnv_rd_n,
    input  logic             cnv_busy,
    input  logic [RES_W-1:0] cnv_data
);
    logic rd_act, wr_act, busy_s, start, pending, hi_read;

    assign rd_act = !host_cs_n && !host_rd_n;
    assign wr_act = !host_cs_n && !host_wr_n;

    adc_bridge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(cnv_busy), .q(busy_s)
    );

    adc_bridge_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_act(wr_act), .busy_s(busy_s),
        .start(start), .pending(pending)
    );

    adc_bridge_rdpath #(.RES_W(RES_W), .BUS_W(BUS_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_act(rd_act), .ready(!pending),
        .start(start), .cnv_data(cnv_data), .dout(host_dout), .hi_read(hi_read)
    );

    assign host_ready  = !(rd_act && pending);
    assign cnv_start_n = !start;
    assign cnv_rd_n    = !hi_read;
    assign cnv_cs_n    = !(hi_read || start);

    // R1: a start pulse is always preceded by a host write
    a_r1_start_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        !cnv_start_n |-> $past(wr_act));
    // R3: a read during a synchronized busy is stalled
    a_r3_stall_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && busy_s) |-> !host_ready);
    // R7: the read bus stays zero outside a completing read
    a_r7_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_act || !host_ready) |-> (host_dout == '0));
    // R5: the converter read strobe only moves inside a host read
    a_r5_cnv_rd_inside: assert property (@(posedge clk) disable iff (!rst_n)
        !cnv_rd_n |-> rd_act);
endmodule

// File: tb/tb_adc_byte_bridge.sv
module tb_adc_byte_bridge;
    localparam int CONV = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_cs_n = 1'b1, host_rd_n = 1'b1, host_wr_n = 1'b1;
    logic [7:0]  host_dout;
    logic        host_ready, cnv_start_n, cnv_cs_n, cnv_rd_n;
    logic        cnv_busy;
    logic [11:0] cnv_data;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    // converter stub
    logic [11:0] result;
    logic [11:0] next_result = 12'h000;
    int          cnt;
    int          conv_count = 0;

    always #10 clk = ~clk;

    adc_byte_bridge dut (
        .clk(clk), .rst_n(rst_n), .host_cs_n(host_cs_n), .host_rd_n(host_rd_n),
        .host_wr_n(host_wr_n), .host_dout(host_dout), .host_ready(host_ready),
        .cnv_start_n(cnv_start_n), .cnv_cs_n(cnv_cs_n), .cnv_rd_n(cnv_rd_n),
        .cnv_busy(cnv_busy), .cnv_data(cnv_data)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnv_busy <= 1'b0;
            result   <= 12'h000;
            cnt      <= 0;
        end else if (!cnv_start_n && !cnv_cs_n) begin
            cnv_busy   <= 1'b1;
            cnt        <= CONV;
            conv_count <= conv_count + 1;
        end else if (cnv_busy) begin
            if (cnt == 1) begin
                cnv_busy <= 1'b0;
                result   <= next_result;
            end
            cnt <= cnt - 1;
        end
    end

    assign cnv_data = (!cnv_cs_n && !cnv_rd_n) ? result : 12'h000;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input bit expect_start, input string req);
        @(negedge clk);
        host_cs_n = 1'b0; host_wr_n = 1'b0;
        @(negedge clk);
        chk(cnv_start_n == !expect_start, req, cnv_start_n, !expect_start);
        if (expect_start) chk(cnv_cs_n == 1'b0, req, cnv_cs_n, 0);
        host_cs_n = 1'b1; host_wr_n = 1'b1;
        @(negedge clk);
        chk(cnv_start_n == 1'b1, req, cnv_start_n, 1);
    endtask

    task automatic host_read(output logic [7:0] val, output int waits, output logic rd_strobe);
        @(negedge clk);
        host_cs_n = 1'b0; host_rd_n = 1'b0;
        #1;
        waits = 0;
        while (!host_ready && waits < 1000) begin
            chk(host_dout == 8'h00, "R7 stalled bus", host_dout, 0);
            @(negedge clk);
            #1;
            waits++;
        end
        val       = host_dout;
        rd_strobe = cnv_rd_n;
        @(negedge clk);
        host_cs_n = 1'b1; host_rd_n = 1'b1;
        #1;
        chk(host_dout == 8'h00, "R7 idle bus", host_dout, 0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        int          w;
        logic        rs;
        logic [11:0] v;
        int          cc;

        repeat (3) @(negedge clk);
        #1;
        // R8 reset values
        chk(cnv_start_n == 1 && cnv_cs_n == 1 && cnv_rd_n == 1, "R8 strobes",
            {cnv_start_n, cnv_cs_n, cnv_rd_n}, 3'b111);
        chk(host_ready == 1, "R8 ready", host_ready, 1);
        chk(host_dout == 0, "R8 dout", host_dout, 0);
        rst_n = 1'b1;
        idle(2);

        // R4 R5 sweep: every upper byte and every lower nibble
        for (int k = 0; k < 256; k++) begin
            v = {k[7:0], k[3:0] ^ k[7:4]};
            next_result = v;
            host_write(1'b1, "R1 start pulse");
            idle(CONV + 8);
            host_read(b, w, rs);
            chk(b == v[11:4], "R4 upper byte", b, v[11:4]);
            chk(rs == 1'b0, "R4 converter read", rs, 0);
            chk(w == 0, "R3 no stall after wait", w, 0);
            host_read(b, w, rs);
            chk(b == {4'h0, v[3:0]}, "R5 lower nibble", b, {4'h0, v[3:0]});
            chk(rs == 1'b1, "R5 latch not converter", rs, 1);
        end

        // R6: a third read wraps back to the upper byte
        host_read(b, w, rs);
        chk(b == v[11:4], "R6 wrap to upper", b, v[11:4]);

        // R6: a new start after only an upper read restarts at the upper byte
        next_result = 12'hA5C;
        host_write(1'b1, "R1 start pulse");
        idle(CONV + 8);
        host_read(b, w, rs);
        chk(b == 8'hA5, "R6 upper after start", b, 8'hA5);
        next_result = 12'h3E7;
        host_write(1'b1, "R1 start pulse");
        idle(CONV + 8);
        host_read(b, w, rs);
        chk(b == 8'h3E, "R6 order reset by start", b, 8'h3E);
        host_read(b, w, rs);
        chk(b == 8'h07, "R6 lower after reset order", b, 8'h07);

        // R3: read right after the start is stalled, then delivers the new data
        next_result = 12'hC39;
        host_write(1'b1, "R1 start pulse");
        host_read(b, w, rs);
        chk(w > 0, "R3 stall seen", w, 1);
        chk(b == 8'hC3, "R3 data after stall", b, 8'hC3);
        host_read(b, w, rs);
        chk(b == 8'h09, "R3 lower after stall", b, 8'h09);

        // R2: second write during a conversion is ignored
        next_result = 12'h6B2;
        cc = conv_count;
        host_write(1'b1, "R1 start pulse");
        idle(2);
        host_write(1'b0, "R2 write ignored");
        idle(CONV + 8);
        chk(conv_count == cc + 1, "R2 one conversion", conv_count, cc + 1);
        host_read(b, w, rs);
        chk(b == 8'h6B, "R2 data intact", b, 8'h6B);

        // R7: read strobe without chip select leaves the bus at zero
        @(negedge clk);
        host_rd_n = 1'b0;
        #1;
        chk(host_dout == 0, "R7 no select", host_dout, 0);
        host_rd_n = 1'b1;
        idle(2);

        done_flag = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule